// File: doc/BRIEF.md
# Memory Polynomial Predistorter

This block sits in a transmit chain between the baseband source and the power amplifier's converter. It applies a memory polynomial to a stream of complex samples: each output is a weighted sum, over eight delays and nine nonlinearity orders, of a delayed input sample scaled by an integer power of that delayed sample's own magnitude. Every one of the 72 basis terms has its own complex coefficient. The coefficients are derived elsewhere and loaded through a write port. The amplifier's expansion is then cancelled by the inverse curve that the coefficients describe.

Each sample is handled in sequence. When a sample is accepted, its magnitude is found once by a bit-serial integer square root. The sample and its magnitude then enter an eight-deep delay line. One multiply-accumulate step per clock walks the 72 coefficients, and the rounded, saturated result is presented on the output stream. The input side is ready only while the block is idle. A sample is taken on a clock edge where both valid and ready are high. The output holds valid, with its data frozen, until the consumer takes it, and no new sample is accepted until then.

Coefficient writes go to a shadow bank at any time. The whole shadow bank is copied to the working bank on the edge that accepts a sample, so a sample already in flight never sees a partial update.

Top module: `mpd_core`

## Requirements
- R1: After reset, `s_ready` is 1 and `m_valid` is 0. The delay line holds zeros. The working coefficients are all zero except index 0, which holds 1.0 (value `2^CFRAC`, 65536 by default).
- R2: With the reset coefficients, every output equals its input sample exactly, on both I and Q.
- R3: The output is z(n) = Σ_{q=0..7} Σ_{k=1..9} c[q·9+(k−1)] · y(n−q) · |y(n−q)|^(k−1). Coefficients are signed 18-bit numbers with `CFRAC` fractional bits, real and imaginary parts written separately. Index = q·9 + (k−1), so the order index runs fastest. Writes to an index of 72 or above are ignored.
- R4: Every delayed sample is scaled by powers of its own stored magnitude, never by the magnitude of the newest sample.
- R5: The magnitude is floor(sqrt(I²+Q²)) as an unsigned Q1.15 value. The power starts at 1.0 (32768) for k=1. Each next power is (previous · magnitude) >> 15, clamped to 2^18−1. Each basis part is (sample · power) >> 15 with arithmetic flooring.
- R6: The accumulated sum is rounded by adding 2^(CFRAC−1) and shifting right arithmetically by `CFRAC`. It is then saturated to the range −32768..32767.
- R7: `s_ready` is high only while idle. Each accepted sample yields exactly one output transfer. While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_re`/`m_im` stay unchanged.
- R8: Coefficient writes land in a shadow bank. The shadow bank is copied to the working bank only on the edge that accepts a sample. A write made while a sample is in flight affects the next sample and not the current one.
- R9: `m_valid` rises exactly 89 clock edges after the accepting edge. This is 16 root steps, plus 1 load step, plus 72 product steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take a sample |
| s_re | input | 16 | Input I, signed Q1.15 |
| s_im | input | 16 | Input Q, signed Q1.15 |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Consumer takes the output |
| m_re | output | 16 | Output I, signed Q1.15 |
| m_im | output | 16 | Output Q, signed Q1.15 |
| cw_en | input | 1 | Coefficient write strobe |
| cw_idx | input | 7 | Coefficient index q·9+(k−1) |
| cw_re | input | 18 | Coefficient real part |
| cw_im | input | 18 | Coefficient imaginary part |

## Verification
On every cycle, the assertions check these properties:
- The root unit's result is the exact floor square root whenever it completes.
- The working bank changes only on an accept edge, and then takes the shadow contents.
- At most one sample is ever in flight.
- A stalled output holds steady.
- The output appears exactly the fixed latency after acceptance.

The arithmetic cannot be checked that way. This covers the coefficient index ordering, the use of each delayed sample's own magnitude, the power clamp, rounding and saturation. It also covers whether a write made mid-flight lands on the right sample. Only the bench's scenarios can show these, by comparing outputs with values worked out from the equation.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
  localparam int SMP_W   = 16;                          // sample width, Q1.15
  localparam int MAG_W   = 16;                          // magnitude width, unsigned Q1.15
  localparam int PW_W    = 18;                          // power width, unsigned Q3.15
  localparam int CW      = 18;                          // coefficient width
  localparam int FRAC_IN = 15;                          // fractional bits of samples
  localparam int BAS_W   = SMP_W + PW_W + 1 - FRAC_IN;  // basis part width

  typedef struct packed {
    logic signed [SMP_W-1:0] re;
    logic signed [SMP_W-1:0] im;
    logic [MAG_W-1:0]        mag;
  } tap_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ROOT, ST_MAC, ST_OUT} mpd_state_e;
endpackage

// File: rtl/mpd_isqrt.sv
module mpd_isqrt #(
  parameter int ROOT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [2*ROOT_W-1:0]   rad,
  output logic                  done,
  output logic [ROOT_W-1:0]     root
);
  localparam int RAD_W = 2 * ROOT_W;
  localparam int BIT_W = $clog2(ROOT_W);

  logic [RAD_W-1:0]  rad_q;
  logic [BIT_W-1:0]  bit_q;
  logic              busy_q;
  logic [ROOT_W-1:0] trial;
  logic [RAD_W-1:0]  trial_sq;

  // one result bit per clock, most significant first
  always_comb begin
    trial    = root | (ROOT_W'(1) << bit_q);
    trial_sq = RAD_W'(trial) * RAD_W'(trial);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rad_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
      root   <= '0;
    end else if (start) begin
      rad_q  <= rad;
      bit_q  <= BIT_W'(ROOT_W - 1);
      busy_q <= 1'b1;
      done   <= 1'b0;
      root   <= '0;
    end else if (busy_q) begin
      if (trial_sq <= rad_q) root <= trial;
      if (bit_q == '0) begin
        busy_q <= 1'b0;
        done   <= 1'b1;
      end else begin
        bit_q <= bit_q - 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  logic [RAD_W+1:0] lo_sq, hi_sq;
  always_comb begin
    lo_sq = (RAD_W+2)'(root) * (RAD_W+2)'(root);
    hi_sq = ((RAD_W+2)'(root) + 1'b1) * ((RAD_W+2)'(root) + 1'b1);
  end

  AST_ROOT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lo_sq <= (RAD_W+2)'(rad_q)) && (hi_sq > (RAD_W+2)'(rad_q))); // R5
endmodule

// File: rtl/mpd_coef_bank.sv
module mpd_coef_bank #(
  parameter int NCOEF = 72,
  parameter int CW    = 18,
  parameter int IDX_W = 7,
  parameter logic signed [CW-1:0] RST0 = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic signed [CW-1:0] wr_re,
  input  logic signed [CW-1:0] wr_im,
  input  logic                 commit,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic signed [CW-1:0] rd_re,
  output logic signed [CW-1:0] rd_im
);
  logic signed [CW-1:0] sh_re  [NCOEF];
  logic signed [CW-1:0] sh_im  [NCOEF];
  logic signed [CW-1:0] act_re [NCOEF];
  logic signed [CW-1:0] act_im [NCOEF];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCOEF; i++) begin
        sh_re[i]  <= '0;
        sh_im[i]  <= '0;
        act_re[i] <= '0;
        act_im[i] <= '0;
      end
      sh_re[0]  <= RST0;
      act_re[0] <= RST0;
    end else begin
      if (commit) begin
        for (int i = 0; i < NCOEF; i++) begin
          act_re[i] <= sh_re[i];
          act_im[i] <= sh_im[i];
        end
      end
      if (wr_en && (int'(wr_idx) < NCOEF)) begin
        sh_re[wr_idx] <= wr_re;
        sh_im[wr_idx] <= wr_im;
      end
    end
  end

  assign rd_re = act_re[rd_idx];
  assign rd_im = act_im[rd_idx];

  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (act_re[NCOEF-1] == $past(sh_re[NCOEF-1])) &&
               (act_im[0] == $past(sh_im[0]))); // R8
  AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_re[0]) && $stable(act_im[NCOEF-1])); // R8
endmodule

// File: rtl/mpd_mac.sv
module mpd_mac
  import mpd_pkg::*;
#(
  parameter int ACC_W = 48,
  parameter int CFRAC = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [SMP_W-1:0] x_re,
  input  logic signed [SMP_W-1:0] x_im,
  input  logic [PW_W-1:0]         pw,
  input  logic signed [CW-1:0]    a_re,
  input  logic signed [CW-1:0]    a_im,
  output logic signed [SMP_W-1:0] y_re,
  output logic signed [SMP_W-1:0] y_im
);
  localparam int PROD_W = SMP_W + PW_W + 1;
  localparam int MUL_W  = CW + BAS_W;
  localparam int SUM_W  = MUL_W + 1;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (CFRAC - 1);
  localparam logic signed [ACC_W-1:0] OMAX = ACC_W'((1 << (SMP_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] OMIN = -OMAX - 1;

  logic signed [PROD_W-1:0] px_re, px_im;
  logic signed [BAS_W-1:0]  b_re, b_im;
  logic signed [MUL_W-1:0]  m_rr, m_ii, m_ri, m_ir;
  logic signed [SUM_W-1:0]  t_re, t_im;
  logic signed [ACC_W-1:0]  acc_re, acc_im, nx_re, nx_im, rd_re, rd_im;

  always_comb begin
    px_re = x_re * $signed({1'b0, pw});
    px_im = x_im * $signed({1'b0, pw});
    b_re  = BAS_W'(px_re >>> FRAC_IN);
    b_im  = BAS_W'(px_im >>> FRAC_IN);
    m_rr  = a_re * b_re;
    m_ii  = a_im * b_im;
    m_ri  = a_re * b_im;
    m_ir  = a_im * b_re;
    t_re  = {m_rr[MUL_W-1], m_rr} - {m_ii[MUL_W-1], m_ii};
    t_im  = {m_ri[MUL_W-1], m_ri} + {m_ir[MUL_W-1], m_ir};
    nx_re = acc_re + {{(ACC_W-SUM_W){t_re[SUM_W-1]}}, t_re};
    nx_im = acc_im + {{(ACC_W-SUM_W){t_im[SUM_W-1]}}, t_im};
    rd_re = (nx_re + HALF) >>> CFRAC;
    rd_im = (nx_im + HALF) >>> CFRAC;
    y_re  = (rd_re > OMAX) ? OMAX[SMP_W-1:0] :
            (rd_re < OMIN) ? OMIN[SMP_W-1:0] : rd_re[SMP_W-1:0];
    y_im  = (rd_im > OMAX) ? OMAX[SMP_W-1:0] :
            (rd_im < OMIN) ? OMIN[SMP_W-1:0] : rd_im[SMP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_re <= '0;
      acc_im <= '0;
    end else if (en) begin
      acc_re <= nx_re;
      acc_im <= nx_im;
    end
  end
endmodule

// File: rtl/mpd_core.sv
module mpd_core
  import mpd_pkg::*;
#(
  parameter int NORD  = 9,
  parameter int NTAP  = 8,
  parameter int CFRAC = 16,
  parameter int ACC_W = 48,
  localparam int IDX_W = $clog2(NORD * NTAP)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic signed [SMP_W-1:0] s_re,
  input  logic signed [SMP_W-1:0] s_im,
  output logic                    m_valid,
  input  logic                    m_ready,
  output logic signed [SMP_W-1:0] m_re,
  output logic signed [SMP_W-1:0] m_im,
  input  logic                    cw_en,
  input  logic [IDX_W-1:0]        cw_idx,
  input  logic signed [CW-1:0]    cw_re,
  input  logic signed [CW-1:0]    cw_im
);
  localparam int NCOEF = NORD * NTAP;
  localparam int ORD_W = $clog2(NORD);
  localparam int TAP_W = $clog2(NTAP);
  localparam int LAT   = MAG_W + 1 + NCOEF;
  localparam logic [PW_W-1:0] PW_ONE = PW_W'(1) << FRAC_IN;
  localparam logic signed [CW-1:0] ONE_C = CW'(1) << CFRAC;

  mpd_state_e              st_q;
  logic signed [SMP_W-1:0] in_re_q, in_im_q;
  tap_t                    tap_q [NTAP];
  tap_t                    cur;
  logic [TAP_W-1:0]        tq_q;
  logic [ORD_W-1:0]        kq_q;
  logic [IDX_W-1:0]        ci_q;
  logic [PW_W-1:0]         pw_q, pw_nxt;
  logic [PW_W+MAG_W-1:0]   pw_prod;
  logic [PW_W:0]           pw_shr;
  logic signed [2*SMP_W-1:0] sq_re, sq_im;
  logic [2*SMP_W-1:0]      rad;
  logic [MAG_W-1:0]        root;
  logic                    accept, root_done, mac_clr, mac_en;
  logic signed [CW-1:0]    a_re, a_im;
  logic signed [SMP_W-1:0] r_re, r_im;

  assign s_ready = (st_q == ST_IDLE);
  assign m_valid = (st_q == ST_OUT);
  assign accept  = s_valid && s_ready;
  assign mac_clr = (st_q == ST_ROOT) && root_done;
  assign mac_en  = (st_q == ST_MAC);
  assign cur     = tap_q[tq_q];

  always_comb begin
    sq_re   = s_re * s_re;
    sq_im   = s_im * s_im;
    rad     = sq_re + sq_im;
    pw_prod = (PW_W+MAG_W)'(pw_q) * (PW_W+MAG_W)'(cur.mag);
    pw_shr  = (PW_W+1)'(pw_prod >> FRAC_IN);
    pw_nxt  = pw_shr[PW_W] ? '1 : pw_shr[PW_W-1:0];
  end

  mpd_isqrt #(.ROOT_W(MAG_W)) u_root (
    .clk  (clk),
    .rst_n(rst_n),
    .start(accept),
    .rad  (rad),
    .done (root_done),
    .root (root)
  );

  mpd_coef_bank #(.NCOEF(NCOEF), .CW(CW), .IDX_W(IDX_W), .RST0(ONE_C)) u_coef (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cw_en),
    .wr_idx(cw_idx),
    .wr_re (cw_re),
    .wr_im (cw_im),
    .commit(accept),
    .rd_idx(ci_q),
    .rd_re (a_re),
    .rd_im (a_im)
  );

  mpd_mac #(.ACC_W(ACC_W), .CFRAC(CFRAC)) u_mac (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (mac_clr),
    .en   (mac_en),
    .x_re (cur.re),
    .x_im (cur.im),
    .pw   (pw_q),
    .a_re (a_re),
    .a_im (a_im),
    .y_re (r_re),
    .y_im (r_im)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      in_re_q <= '0;
      in_im_q <= '0;
      tq_q    <= '0;
      kq_q    <= '0;
      ci_q    <= '0;
      pw_q    <= PW_ONE;
      m_re    <= '0;
      m_im    <= '0;
      for (int i = 0; i < NTAP; i++) tap_q[i] <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          in_re_q <= s_re;
          in_im_q <= s_im;
          st_q    <= ST_ROOT;
        end
        ST_ROOT: if (root_done) begin
          tap_q[0] <= '{re: in_re_q, im: in_im_q, mag: root};
          for (int i = 1; i < NTAP; i++) tap_q[i] <= tap_q[i-1];
          tq_q <= '0;
          kq_q <= '0;
          ci_q <= '0;
          pw_q <= PW_ONE;
          st_q <= ST_MAC;
        end
        ST_MAC: begin
          ci_q <= ci_q + 1'b1;
          if (kq_q == ORD_W'(NORD - 1)) begin
            kq_q <= '0;
            tq_q <= tq_q + 1'b1;
            pw_q <= PW_ONE;
          end else begin
            kq_q <= kq_q + 1'b1;
            pw_q <= pw_nxt;
          end
          if (ci_q == IDX_W'(NCOEF - 1)) begin
            m_re <= r_re;
            m_im <= r_im;
            st_q <= ST_OUT;
          end
        end
        ST_OUT: if (m_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // in-flight and latency bookkeeping used only by the assertions
  logic [1:0]  infl_q;
  logic [15:0] lat_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      infl_q <= '0;
      lat_q  <= '0;
    end else begin
      case ({accept, m_valid && m_ready})
        2'b10:   infl_q <= infl_q + 1'b1;
        2'b01:   infl_q <= infl_q - 1'b1;
        default: infl_q <= infl_q;
      endcase
      if (accept) lat_q <= '0;
      else if (!m_valid) lat_q <= lat_q + 1'b1;
    end
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (infl_q <= 2'd1) && ((m_valid && m_ready) -> (infl_q == 2'd1))); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid && $stable(m_re) && $stable(m_im)); // R7
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> (lat_q == 16'(LAT))); // R9
endmodule

// File: tb/mpd_core_tb_top.sv
module mpd_core_tb_top;
  localparam int NC    = 72;
  localparam int NO    = 9;
  localparam int NT    = 8;
  localparam int CFR   = 16;
  localparam int LATX  = 89;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, m_ready = 1'b1, cw_en = 1'b0;
  logic s_ready, m_valid;
  logic signed [15:0] s_re = '0, s_im = '0, m_re, m_im;
  logic [6:0] cw_idx = '0;
  logic signed [17:0] cw_re = '0, cw_im = '0;

  always #2 clk = ~clk;

  mpd_core dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_re(s_re), .s_im(s_im),
    .m_valid(m_valid), .m_ready(m_ready), .m_re(m_re), .m_im(m_im),
    .cw_en(cw_en), .cw_idx(cw_idx), .cw_re(cw_re), .cw_im(cw_im)
  );

  int checks = 0, errors = 0;
  longint cyc = 0, acc_cyc = 0;
  bit finished = 0;
  longint sh_re[NC], sh_im[NC], ac_re[NC], ac_im[NC];
  longint h_re[NT], h_im[NT];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint isq(longint v);
    longint r = longint'($floor($sqrt(real'(v))));
    while (r * r > v) r--;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

  function automatic longint sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // equation-level reference built from the requirement text
  task automatic model(output longint zr, output longint zi);
    longint ar = 0, ai = 0;
    for (int q = 0; q < NT; q++) begin
      longint m = isq(h_re[q] * h_re[q] + h_im[q] * h_im[q]);
      longint pw = 32768;
      for (int k = 0; k < NO; k++) begin
        int i = q * NO + k;
        longint br = (h_re[q] * pw) >>> 15;
        longint bi = (h_im[q] * pw) >>> 15;
        ar += ac_re[i] * br - ac_im[i] * bi;
        ai += ac_re[i] * bi + ac_im[i] * br;
        pw = (pw * m) >> 15;
        if (pw > 262143) pw = 262143;
      end
    end
    zr = sat16((ar + (longint'(1) << (CFR - 1))) >>> CFR);
    zi = sat16((ai + (longint'(1) << (CFR - 1))) >>> CFR);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; s_valid = 1'b0; cw_en = 1'b0; m_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NC; i++) begin
      sh_re[i] = 0; sh_im[i] = 0; ac_re[i] = 0; ac_im[i] = 0;
    end
    sh_re[0] = 65536; ac_re[0] = 65536;
    for (int i = 0; i < NT; i++) begin h_re[i] = 0; h_im[i] = 0; end
  endtask

  task automatic wr_coef(int idx, longint re, longint im);
    @(negedge clk);
    cw_en = 1'b1; cw_idx = 7'(idx); cw_re = 18'(re); cw_im = 18'(im);
    @(negedge clk);
    cw_en = 1'b0;
    if (idx < NC) begin sh_re[idx] = re; sh_im[idx] = im; end
  endtask

  task automatic issue(longint re, longint im);
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_re = 16'(re); s_im = 16'(im);
    @(posedge clk);
    for (int i = 0; i < NC; i++) begin ac_re[i] = sh_re[i]; ac_im[i] = sh_im[i]; end
    for (int i = NT - 1; i > 0; i--) begin h_re[i] = h_re[i-1]; h_im[i] = h_im[i-1]; end
    h_re[0] = re; h_im[0] = im;
    @(negedge clk);
    acc_cyc = cyc;
    s_valid = 1'b0;
  endtask

  task automatic collect(output longint zr, output longint zi, output longint lat);
    int guard = 0;
    while (!m_valid && guard < 400) begin @(negedge clk); guard++; end
    lat = cyc - acc_cyc;
    zr = m_re; zi = m_im;
    @(posedge clk);
  endtask

  task automatic run_cmp(string req, longint re, longint im);
    longint er, ei, gr, gi, lat;
    issue(re, im);
    model(er, ei);
    collect(gr, gi, lat);
    chk(req, "out I", gr, er);
    chk(req, "out Q", gi, ei);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1", "s_ready after reset", s_ready, 1);
    chk("R1", "m_valid after reset", m_valid, 0);
  endtask

  task automatic t_passthrough();
    longint gr, gi, lat;
    longint vr[5] = '{12345, 32767, -1, 0, -20000};
    longint vi[5] = '{-2222, -32768, 1, 0, 31000};
    do_reset();
    for (int i = 0; i < 5; i++) begin
      issue(vr[i], vi[i]);
      collect(gr, gi, lat);
      chk("R2", "pass I", gr, vr[i]);
      chk("R2", "pass Q", gi, vi[i]);
      chk("R9", "latency", lat, LATX);
    end
  endtask

  task automatic t_ordering();
    longint gr, gi, lat;
    do_reset();
    wr_coef(0, 0, 0);
    wr_coef(1, 65536, 0);              // k=2, q=0
    issue(16384, 0);
    collect(gr, gi, lat);
    chk("R3", "x*|x| hand value I", gr, 8192);
    chk("R3", "x*|x| hand value Q", gi, 0);
    wr_coef(1, 0, 0);
    wr_coef(3 * NO + 4, 0, 40000);     // k=5, q=3
    wr_coef(NO + 0, -30000, 12000);    // k=1, q=1
    wr_coef(100, 65536, 65536);        // out of range, ignored
    for (int i = 0; i < 6; i++)
      run_cmp("R3", 5000 * i - 12000, 30000 - 7000 * i);
  endtask

  task automatic t_memory();
    longint gr, gi, lat;
    do_reset();
    wr_coef(0, 0, 0);
    wr_coef(2 * NO + 2, 65536, 0);     // k=3, q=2
    issue(32767, 0);
    collect(gr, gi, lat);
    issue(100, 0);
    collect(gr, gi, lat);
    issue(100, 0);
    collect(gr, gi, lat);
    // y(n-2)=32767, |y|^2 ~ 1.0 ; own magnitude gives about 32765, current one near 0
    chk("R4", "uses delayed own magnitude", (gr > 32000) ? 1 : 0, 1);
    do_reset();
    wr_coef(0, 0, 0);
    wr_coef(7 * NO + 8, 3000, -2000);  // k=9, q=7: clamped power
    wr_coef(4 * NO + 6, 9000, 500);    // k=7, q=4
    wr_coef(0 * NO + 3, -7000, 0);     // k=4, q=0
    for (int i = 0; i < 10; i++)
      run_cmp("R5", (i % 2) ? 32767 : -30000 + 3000 * i, (i % 3) ? 32767 : 1000 * i);
  endtask

  task automatic t_round_sat();
    longint gr, gi, lat;
    do_reset();
    wr_coef(0, 32768, 0);              // 0.5
    issue(3, -3);
    collect(gr, gi, lat);
    chk("R6", "round +1.5", gr, 2);
    chk("R6", "round -1.5", gi, -1);
    wr_coef(0, 131071, 0);             // ~2.0
    issue(32767, -32768);
    collect(gr, gi, lat);
    chk("R6", "saturate high", gr, 32767);
    chk("R6", "saturate low", gi, -32768);
  endtask

  task automatic t_backpressure();
    longint gr, gi, lat;
    logic signed [15:0] hr, hi;
    do_reset();
    @(negedge clk); m_ready = 1'b0;
    issue(-4321, 1234);
    while (!m_valid) @(negedge clk);
    hr = m_re; hi = m_im;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!m_valid || m_re != hr || m_im != hi || s_ready) begin
        chk("R7", "hold under stall", 0, 1);
      end
    end
    chk("R7", "held I", hr, -4321);
    chk("R7", "s_ready low while held", s_ready, 0);
    m_ready = 1'b1;
    @(negedge clk);
    chk("R7", "m_valid drops after transfer", m_valid, 0);
    chk("R7", "s_ready back", s_ready, 1);
    issue(777, -888);
    collect(gr, gi, lat);
    chk("R7", "next sample single output", gr, 777);
  endtask

  task automatic t_shadow();
    longint gr, gi, lat;
    do_reset();
    issue(1000, -1000);
    wr_coef(0, 32768, 0);              // lands mid-flight
    collect(gr, gi, lat);
    chk("R8", "in-flight uses old I", gr, 1000);
    chk("R8", "in-flight uses old Q", gi, -1000);
    issue(1001, -999);
    collect(gr, gi, lat);
    chk("R8", "next uses new I", gr, 501);
    chk("R8", "next uses new Q", gi, -499);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_passthrough();
    t_ordering();
    t_memory();
    t_round_sat();
    t_backpressure();
    t_shadow();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule